// File: doc/BRIEF.md
# VLIW Packet Unpacker and Slot Dispatcher

This block sits between an instruction cache and four issue slots. Each fetch word holds four 32-bit instructions in address order, with lane 0 in the lowest bits. Memory holds no no-ops. Instead, every instruction carries an end-of-packet flag, so an execution packet holds one to four instructions and may run on into the next fetch word. The block reassembles each packet and routes each instruction by its unit class. Integer work goes to slots 0 and 1. Combined floating-point/media work goes to slots 2 and 3. Every slot the packet leaves empty is filled with a generated no-op.

Bundles leave through a valid/ready handshake, one packet per bundle. Instructions left over from a fetch word stay in a three-entry holding store. A new fetch word is accepted only after that store no longer holds a complete packet. A malformed packet is dropped and reported with a one-cycle error pulse. A synchronous flush clears everything in flight.

Top module: `vliw_unpacker`

## Requirements
- R1: After reset, `issue_valid_o` and `pkt_err_o` are 0 and `fetch_ready_o` is 1 while `issue_ready_i` is 1.
- R2: Bit 31 of an instruction set to 1 marks the last instruction of its packet. A packet is taken from consecutive instructions in address order, lane 0 first within a word, and each issued bundle holds exactly one packet with at least one valid slot.
- R3: Bits 30:29 give the unit class. 00 (integer) fills slots 0 then 1 in program order, and 01 (floating-point/media) fills slots 2 then 3. Slot s occupies bits s*32+31:s*32 of `issue_data_o`. The bundle appears on the cycle after the word that completes the packet is accepted.
- R4: Each unused slot carries 32'h8000_0000 and has its bit in `issue_slot_valid_o` at 0.
- R5: Instructions left after a packet ends mid-word are kept, up to three of them, and issue one packet per cycle. A packet may span two fetch words. `fetch_ready_o` is 0 while the kept instructions contain a complete packet.
- R6: A packet that contains class 10 or 11, or more than two instructions of one class, is dropped. No bundle is issued for it, and `pkt_err_o` pulses for one cycle in the cycle where its bundle would have appeared.
- R7: If none of the first four instructions of a packet has its end flag set, `pkt_err_o` pulses and every instruction up to and including the next set flag is discarded, including instructions in later fetch words.
- R8: While `flush_i` is 1, `fetch_ready_o` is 0. On the next cycle no bundle is valid and no kept instruction survives.
- R9: While `issue_valid_o` is 1 and `issue_ready_i` is 0, the bundle stays unchanged and `fetch_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous flush of kept instructions and the pending bundle |
| fetch_valid_i | input | 1 | Fetch word is present |
| fetch_data_i | input | 128 | Four instructions, lane 0 in bits 31:0 |
| fetch_ready_o | output | 1 | Fetch word is accepted this cycle when valid |
| issue_valid_o | output | 1 | Bundle is present |
| issue_ready_i | input | 1 | Consumer takes the bundle |
| issue_data_o | output | 128 | Four slots, slot 0 in bits 31:0 |
| issue_slot_valid_o | output | 4 | Per-slot valid bit |
| pkt_err_o | output | 1 | One-cycle pulse for a dropped packet |

## Verification
The assertions assume that `issue_ready_i` and `flush_i` are driven to known levels on every cycle after reset. They also assume that the consumer keeps `issue_ready_i` low only for a finite time, so held bundles do eventually drain. The stimulus changes every input one time unit after the rising edge and holds `fetch_valid_i` only across cycles the test plans for. Its word sequences never depend on a fetch word being kept waiting, because it times each word to a cycle in which the holding store is known to be free of complete packets.

// File: rtl/vliw_pkg.sv
package vliw_pkg;

    typedef enum logic [1:0] {
        CLS_INT  = 2'b00,
        CLS_FPM  = 2'b01,
        CLS_RSV2 = 2'b10,
        CLS_RSV3 = 2'b11
    } ucls_e;

    function automatic ucls_e unit_class(input logic [1:0] bits);
        return ucls_e'(bits);
    endfunction

endpackage

// File: rtl/vliw_flag_scan.sv
module vliw_flag_scan #(
    parameter int N     = 7,
    parameter int IW    = 32,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0][IW-1:0] win_i,
    input  logic [CNT_W-1:0]     cnt_i,
    output logic                 found_o,
    output logic [CNT_W-1:0]     idx_o
);

    // lowest populated position whose end flag is set
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (CNT_W'(i) < cnt_i && win_i[i][IW-1]) begin
                found_o = 1'b1;
                idx_o   = CNT_W'(i);
            end
        end
    end

endmodule

// File: rtl/vliw_slot_router.sv
module vliw_slot_router
    import vliw_pkg::*;
#(
    parameter int              INSTR_W   = 32,
    parameter int              LANES     = 4,
    parameter int              INT_SLOTS = 2,
    parameter int              CNT_W     = 3,
    parameter logic [INSTR_W-1:0] NOP_WORD = 32'h8000_0000
) (
    input  logic [LANES-1:0][INSTR_W-1:0] pkt_i,
    input  logic [CNT_W-1:0]              len_i,
    output logic [LANES-1:0][INSTR_W-1:0] slot_o,
    output logic [LANES-1:0]              vld_o,
    output logic                          bad_o
);

    localparam int FPM_SLOTS = LANES - INT_SLOTS;
    localparam int SEL_W     = $clog2(LANES);

    logic [SEL_W:0] n_int, n_fpm, pos;

    always_comb begin
        slot_o = {LANES{NOP_WORD}};
        vld_o  = '0;
        bad_o  = 1'b0;
        n_int  = '0;
        n_fpm  = '0;
        pos    = '0;
        for (int i = 0; i < LANES; i++) begin
            if (CNT_W'(i) < len_i) begin
                case (unit_class(pkt_i[i][INSTR_W-2 -: 2]))
                    CLS_INT: begin
                        if (n_int < (SEL_W+1)'(INT_SLOTS)) begin
                            pos = n_int;
                            slot_o[pos[SEL_W-1:0]] = pkt_i[i];
                            vld_o[pos[SEL_W-1:0]]  = 1'b1;
                            n_int = n_int + (SEL_W+1)'(1);
                        end else begin
                            bad_o = 1'b1;
                        end
                    end
                    CLS_FPM: begin
                        if (n_fpm < (SEL_W+1)'(FPM_SLOTS)) begin
                            pos = (SEL_W+1)'(INT_SLOTS) + n_fpm;
                            slot_o[pos[SEL_W-1:0]] = pkt_i[i];
                            vld_o[pos[SEL_W-1:0]]  = 1'b1;
                            n_fpm = n_fpm + (SEL_W+1)'(1);
                        end else begin
                            bad_o = 1'b1;
                        end
                    end
                    default: bad_o = 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/vliw_unpacker.sv
module vliw_unpacker #(
    parameter int                 INSTR_W   = 32,
    parameter int                 LANES     = 4,
    parameter int                 INT_SLOTS = 2,
    parameter logic [INSTR_W-1:0] NOP_WORD  = 32'h8000_0000
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       flush_i,
    input  logic                       fetch_valid_i,
    input  logic [LANES*INSTR_W-1:0]   fetch_data_i,
    output logic                       fetch_ready_o,
    output logic                       issue_valid_o,
    input  logic                       issue_ready_i,
    output logic [LANES*INSTR_W-1:0]   issue_data_o,
    output logic [LANES-1:0]           issue_slot_valid_o,
    output logic                       pkt_err_o
);

    localparam int BUF_DEPTH = LANES - 1;
    localparam int WIN       = BUF_DEPTH + LANES;
    localparam int CNT_W     = $clog2(WIN + 1);
    localparam int FLAG_BIT  = INSTR_W - 1;

    typedef struct packed {
        logic [BUF_DEPTH-1:0][INSTR_W-1:0] hold;
        logic [CNT_W-1:0]                  bcnt;
        logic                              drop;
        logic                              ovld;
        logic [LANES-1:0][INSTR_W-1:0]     slot;
        logic [LANES-1:0]                  svld;
        logic                              err;
    } st_t;

    st_t q, d;

    logic                          step, take, hold_end;
    logic [WIN-1:0][INSTR_W-1:0]   win;
    logic [CNT_W-1:0]              wcnt, fidx, consume;
    logic                          found, bad;
    logic [LANES-1:0][INSTR_W-1:0] r_slots;
    logic [LANES-1:0]              r_vld;

    // a kept complete packet blocks new fetch words
    always_comb begin
        hold_end = 1'b0;
        for (int i = 0; i < BUF_DEPTH; i++) begin
            if (CNT_W'(i) < q.bcnt && q.hold[i][FLAG_BIT]) hold_end = 1'b1;
        end
    end

    assign step          = !flush_i && (!q.ovld || issue_ready_i);
    assign fetch_ready_o = step && !hold_end;
    assign take          = fetch_valid_i && fetch_ready_o;

    // kept instructions first, then the accepted word
    always_comb begin
        win = '0;
        for (int i = 0; i < BUF_DEPTH; i++) begin
            if (CNT_W'(i) < q.bcnt) win[i] = q.hold[i];
        end
        for (int i = 0; i < WIN; i++) begin
            for (int l = 0; l < LANES; l++) begin
                if (take && CNT_W'(i) == q.bcnt + CNT_W'(l))
                    win[i] = fetch_data_i[l*INSTR_W +: INSTR_W];
            end
        end
        wcnt = q.bcnt + (take ? CNT_W'(LANES) : '0);
    end

    vliw_flag_scan #(
        .N     (WIN),
        .IW    (INSTR_W),
        .CNT_W (CNT_W)
    ) u_scan (
        .win_i   (win),
        .cnt_i   (wcnt),
        .found_o (found),
        .idx_o   (fidx)
    );

    vliw_slot_router #(
        .INSTR_W   (INSTR_W),
        .LANES     (LANES),
        .INT_SLOTS (INT_SLOTS),
        .CNT_W     (CNT_W),
        .NOP_WORD  (NOP_WORD)
    ) u_route (
        .pkt_i  (win[LANES-1:0]),
        .len_i  (fidx + CNT_W'(1)),
        .slot_o (r_slots),
        .vld_o  (r_vld),
        .bad_o  (bad)
    );

    always_comb begin
        d       = q;
        d.err   = 1'b0;
        consume = '0;
        if (step) begin
            d.ovld = 1'b0;
            if (q.drop) begin
                if (take) begin
                    if (found) begin
                        consume = fidx + CNT_W'(1);
                        d.drop  = 1'b0;
                    end else begin
                        consume = wcnt;
                    end
                end
            end else if (found && fidx < CNT_W'(LANES)) begin
                consume = fidx + CNT_W'(1);
                if (bad) begin
                    d.err = 1'b1;
                end else begin
                    d.ovld = 1'b1;
                    d.slot = r_slots;
                    d.svld = r_vld;
                end
            end else if (found) begin
                consume = fidx + CNT_W'(1);
                d.err   = 1'b1;
            end else if (wcnt >= CNT_W'(LANES)) begin
                consume = wcnt;
                d.err   = 1'b1;
                d.drop  = 1'b1;
            end
        end
        d.bcnt = wcnt - consume;
        for (int i = 0; i < BUF_DEPTH; i++) begin
            d.hold[i] = '0;
            for (int j = 0; j < WIN; j++) begin
                if ((CNT_W+1)'(j) == (CNT_W+1)'(i) + {1'b0, consume}) d.hold[i] = win[j];
            end
        end
        if (flush_i) d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign issue_valid_o      = q.ovld;
    assign issue_data_o       = q.slot;
    assign issue_slot_valid_o = q.svld;
    assign pkt_err_o          = q.err;

    // ---------------- assertions ----------------
    assert_bundle_nonempty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_valid_o |-> $countones(issue_slot_valid_o) != 0);

    assert_int_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_valid_o && issue_slot_valid_o[1]) |-> issue_slot_valid_o[0]);

    assert_fpm_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_valid_o && issue_slot_valid_o[3]) |-> issue_slot_valid_o[2]);

    for (genvar s = 0; s < LANES; s++) begin : g_nop_chk
        assert_nop_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (issue_valid_o && !issue_slot_valid_o[s]) |->
                issue_data_o[s*INSTR_W +: INSTR_W] == NOP_WORD);
    end

    assert_hold_fits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.bcnt <= CNT_W'(BUF_DEPTH));

    assert_err_no_bundle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_err_o |-> !issue_valid_o);

    assert_flush_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (!issue_valid_o && !pkt_err_o));

    assert_flush_noaccept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |-> !fetch_ready_o);

    assert_hold_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_valid_o && !issue_ready_i && !flush_i) |=>
            (issue_valid_o && $stable(issue_data_o) && $stable(issue_slot_valid_o)));

    assert_stall_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_valid_o && !issue_ready_i) |-> !fetch_ready_o);

endmodule

// File: tb/tb_vliw_unpacker.sv
module tb_vliw_unpacker;

    localparam logic [31:0] NOP = 32'h8000_0000;

    typedef struct packed {
        logic [127:0] word;
        logic [127:0] data;
        logic [3:0]   sv;
        logic         err;
    } vec_t;

    // one packet per word, starting at lane 0; remainder flushed afterwards
    localparam vec_t VECS [8] = '{
        '{ {32'h80000014, 32'h80000013, 32'h80000012, 32'h80000011},
           {NOP, NOP, NOP, 32'h80000011}, 4'b0001, 1'b0 },
        '{ {32'h80000024, 32'h80000023, 32'hA0000022, 32'h00000021},
           {NOP, 32'hA0000022, NOP, 32'h00000021}, 4'b0101, 1'b0 },
        '{ {32'h80000034, 32'h00000033, 32'h20000032, 32'h20000031},
           {32'h20000032, 32'h20000031, 32'h80000034, 32'h00000033}, 4'b1111, 1'b0 },
        '{ {32'h80000044, 32'hA0000043, 32'h00000042, 32'h20000041},
           {32'hA0000043, 32'h20000041, NOP, 32'h00000042}, 4'b1101, 1'b0 },
        '{ {32'h80000054, 32'h80000053, 32'h00000052, 32'h00000051},
           128'h0, 4'b0000, 1'b1 },
        '{ {32'h80000064, 32'h80000063, 32'h80000062, 32'hC0000061},
           128'h0, 4'b0000, 1'b1 },
        '{ {32'h80000074, 32'hA0000073, 32'h20000072, 32'h20000071},
           128'h0, 4'b0000, 1'b1 },
        '{ {32'h80000084, 32'h80000083, 32'h80000082, 32'h60000081},
           128'h0, 4'b0000, 1'b1 }
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         f_valid = 1'b0;
    logic [127:0] f_data = '0;
    logic         f_ready;
    logic         i_valid;
    logic         i_ready = 1'b1;
    logic [127:0] i_data;
    logic [3:0]   i_sv;
    logic         p_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    vliw_unpacker dut (
        .clk_i              (clk),
        .rst_ni             (rst_n),
        .flush_i            (flush),
        .fetch_valid_i      (f_valid),
        .fetch_data_i       (f_data),
        .fetch_ready_o      (f_ready),
        .issue_valid_o      (i_valid),
        .issue_ready_i      (i_ready),
        .issue_data_o       (i_data),
        .issue_slot_valid_o (i_sv),
        .pkt_err_o          (p_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_val(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_bundle(input string tag, input logic [127:0] d, input logic [3:0] sv);
        check_val({tag, " valid"}, {127'h0, i_valid}, 128'h1);
        check_val({tag, " data"}, i_data, d);
        check_val({tag, " slot valid"}, {124'h0, i_sv}, {124'h0, sv});
        check_val({tag, " err"}, {127'h0, p_err}, 128'h0);
    endtask

    task automatic expect_idle(input string tag, input logic e);
        check_val({tag, " valid"}, {127'h0, i_valid}, 128'h0);
        check_val({tag, " err"}, {127'h0, p_err}, {127'h0, e});
    endtask

    function automatic logic [127:0] one(input logic [31:0] s0);
        return {NOP, NOP, NOP, s0};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1 reset state
        expect_idle("R1 reset", 1'b0);
        check_val("R1 fetch ready", {127'h0, f_ready}, 128'h1);

        // table: R2 R3 R4 R6, each followed by a flush (R8)
        foreach (VECS[k]) begin
            f_data  = VECS[k].word;
            f_valid = 1'b1;
            tick();
            f_valid = 1'b0;
            flush   = 1'b1;
            if (VECS[k].err) expect_idle("R6 bad class mix", 1'b1);
            else             expect_bundle("R3 routing", VECS[k].data, VECS[k].sv);
            #1;
            check_val("R8 no fetch during flush", {127'h0, f_ready}, 128'h0);
            tick();
            flush = 1'b0;
            expect_idle("R8 flush clears bundle", 1'b0);
            tick();
            expect_idle("R8 flush clears kept", 1'b0);
        end

        // R5 packet spanning two words, then kept single packets
        f_data  = {32'h20000104, 32'h20000103, 32'h00000102, 32'h80000101};
        f_valid = 1'b1;
        tick();
        expect_bundle("R2 first packet", one(32'h80000101), 4'b0001);
        f_data = {32'h80000108, 32'h80000107, 32'h80000106, 32'h80000105};
        #1;
        check_val("R5 ready with partial kept", {127'h0, f_ready}, 128'h1);
        tick();
        f_valid = 1'b0;
        expect_bundle("R5 spanning packet",
            {32'h20000104, 32'h20000103, 32'h80000105, 32'h00000102}, 4'b1111);
        check_val("R5 ready low with kept packet", {127'h0, f_ready}, 128'h0);
        tick();
        expect_bundle("R5 kept 1", one(32'h80000106), 4'b0001);
        tick();
        expect_bundle("R5 kept 2", one(32'h80000107), 4'b0001);
        tick();
        expect_bundle("R5 kept 3", one(32'h80000108), 4'b0001);
        tick();
        expect_idle("R5 drained", 1'b0);
        check_val("R5 ready after drain", {127'h0, f_ready}, 128'h1);

        // R9 backpressure
        f_data  = {32'h80000204, 32'h80000203, 32'h80000202, 32'h80000201};
        f_valid = 1'b1;
        tick();
        f_valid = 1'b0;
        i_ready = 1'b0;
        expect_bundle("R9 first", one(32'h80000201), 4'b0001);
        for (int c = 0; c < 3; c++) begin
            tick();
            expect_bundle("R9 held", one(32'h80000201), 4'b0001);
            check_val("R9 fetch blocked", {127'h0, f_ready}, 128'h0);
        end
        i_ready = 1'b1;
        tick();
        expect_bundle("R9 release 2", one(32'h80000202), 4'b0001);
        tick();
        expect_bundle("R9 release 3", one(32'h80000203), 4'b0001);
        tick();
        expect_bundle("R9 release 4", one(32'h80000204), 4'b0001);
        tick();
        expect_idle("R9 drained", 1'b0);

        // R7 no end flag in a full word: discard into the next word
        f_data  = {32'h20000304, 32'h20000303, 32'h00000302, 32'h00000301};
        f_valid = 1'b1;
        tick();
        expect_idle("R7 missing end flag", 1'b1);
        f_data = {32'h80000308, 32'h80000307, 32'h80000306, 32'h00000305};
        tick();
        f_valid = 1'b0;
        expect_idle("R7 discard through flag", 1'b0);
        tick();
        expect_bundle("R7 resume 1", one(32'h80000307), 4'b0001);
        tick();
        expect_bundle("R7 resume 2", one(32'h80000308), 4'b0001);
        tick();
        expect_idle("R7 drained", 1'b0);

        // R7 overlong packet spanning kept instructions and a new word
        f_data  = {32'h00000404, 32'h00000403, 32'h00000402, 32'h80000401};
        f_valid = 1'b1;
        tick();
        expect_bundle("R7 lead packet", one(32'h80000401), 4'b0001);
        f_data = {32'h80000408, 32'h80000407, 32'h80000406, 32'h00000405};
        tick();
        f_valid = 1'b0;
        expect_idle("R7 overlong packet", 1'b1);
        tick();
        expect_bundle("R7 after overlong 1", one(32'h80000407), 4'b0001);
        tick();
        expect_bundle("R7 after overlong 2", one(32'h80000408), 4'b0001);
        tick();
        expect_idle("R7 overlong drained", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule